// File: doc/BRIEF.md
# Scroll-Layer Register Bank with Indirect Tile-Index Port

This block sits on the main processor's 16-bit bus and holds the register state for three scrolling background layers. Each layer has a small window of three words: an X scroll value, a Y scroll value and a tile pointer. The tile index storage for each layer lives inside the block. It has no direct address window. Software first loads a layer's pointer and then reads or writes the entry it selects through that layer's own data port. The pointer never advances by itself, so any number of port accesses all reach the same entry until software reloads the pointer.

A mode register switches which half of the tile graphics layer 2 fetches from, and it gates a level-4 interrupt request. The scroll values, the bank select and the gated interrupt are outputs for the rendering and interrupt logic. That logic is outside this block.

Each bus access is a one-cycle strobe. A read returns its data combinationally in the strobe cycle. Any address the block decodes gets a one-cycle acknowledge in the following cycle. Addresses the block does not decode get no acknowledge and read as zero.

Top module: `tile_layer_regs`

## Requirements
- R1: On reset, every X scroll, Y scroll and tile pointer reads zero, the layer-2 bank select and the interrupt enable are zero, and the acknowledge is low.
- R2: Layer n's window starts at byte address 0x70000 + n*0x2000 (n = 0..2). Offset 0 is the X scroll and offset 2 is the Y scroll, both 16 bits and readable. A write appears on scroll_x/scroll_y slice n (bits 16n+15..16n) from the cycle after the strobe.
- R3: Offset 4 of each window is a 16-bit tile pointer that reads back as written. Data port accesses never change it.
- R4: Layer n's data port is at byte address 0x7E000 + 2n. A write stores the data word in the entry chosen by that layer's pointer. A read returns that entry.
- R5: Bit 0 of the address is ignored. A strobe to a decoded address is acknowledged for exactly one cycle, in the next cycle. Other addresses are never acknowledged: window offset 6, 0x7800C, 0x7E006 and anything outside the block. bus_rdata is zero except during a read strobe to a decoded address.
- R6: Tile storage is separate per layer. A write through one layer's port leaves every other layer's entries unchanged.
- R7: A write to the mode register at 0x7800E compares only data bits 7..0. Value 10 clears the layer-2 bank select (lower tileset) and value 11 sets it (upper tileset). A read returns the bank select in bit 0.
- R8: Writing value 14 to the mode register sets the interrupt enable, which reads back in bit 1 and stays set until reset. irq4_out equals irq4_req while the enable is set and is 0 otherwise. All other values leave the bank select and the enable unchanged.
- R9: Only pointer bits TILE_AW-1..0 select an entry (8 bits by default). Pointers that differ only above that reach the same entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | One-cycle access strobe |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 20 | Byte address; bit 0 ignored |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the strobe cycle |
| bus_ack | output | 1 | Acknowledge, one cycle after a decoded strobe |
| irq4_req | input | 1 | Raw level-4 interrupt request |
| irq4_out | output | 1 | Request gated by the interrupt enable |
| layer_bank | output | 1 | Layer-2 tileset half: 0 lower, 1 upper |
| scroll_x | output | 48 | X scroll of layers 2..0, 16 bits each |
| scroll_y | output | 48 | Y scroll of layers 2..0, 16 bits each |

## Verification
A pointer that is corrupted or that advances on its own shows up on the next port read as data from the wrong entry, and on the next pointer read as a wrong value. A decode fault shows up in the very next cycle as a missing or extra acknowledge, or in the strobe cycle itself as wrong read data. Scroll, bank and interrupt state are outputs, so any wrong value in them differs from the model in the first cycle after the write that should have set it.

// File: rtl/tlr_pkg.sv
package tlr_pkg;
   typedef enum logic [1:0] {
      FLD_X    = 2'd0,
      FLD_Y    = 2'd1,
      FLD_PTR  = 2'd2,
      FLD_NONE = 2'd3
   } tlr_field_e;

   localparam int unsigned CTRL_BANK_BIT = 0;
   localparam int unsigned CTRL_IRQ_BIT  = 1;
endpackage

// File: rtl/tlr_decode.sv
module tlr_decode
   import tlr_pkg::*;
#(
   parameter int          ADDR_W     = 20,
   parameter int          NUM_LAYERS = 3,
   parameter int unsigned WIN_BASE   = 32'h70000,
   parameter int unsigned WIN_STRIDE = 32'h2000,
   parameter int unsigned PORT_BASE  = 32'h7E000,
   parameter int unsigned CTRL_ADDR  = 32'h7800E
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     addr,
   output logic [NUM_LAYERS-1:0] win_hit,
   output tlr_field_e            win_fld,
   output logic [NUM_LAYERS-1:0] port_hit,
   output logic                  ctrl_hit,
   output logic                  any_hit
);
   localparam logic [31:0] CTRL_A = 32'(CTRL_ADDR);

   logic unused_addr_lsb;
   assign unused_addr_lsb = addr[0];

   always_comb begin
      case (addr[2:1])
         2'd0:    win_fld = FLD_X;
         2'd1:    win_fld = FLD_Y;
         2'd2:    win_fld = FLD_PTR;
         default: win_fld = FLD_NONE;
      endcase
   end

   for (genvar g = 0; g < NUM_LAYERS; g++) begin : g_layer_dec
      localparam logic [31:0] WB = 32'(WIN_BASE + 32'(g) * WIN_STRIDE);
      localparam logic [31:0] PB = 32'(PORT_BASE + 32'(g) * 32'd2);
      assign win_hit[g]  = (addr[ADDR_W-1:3] == WB[ADDR_W-1:3]) && (win_fld != FLD_NONE);
      assign port_hit[g] = (addr[ADDR_W-1:1] == PB[ADDR_W-1:1]);
   end

   assign ctrl_hit = (addr[ADDR_W-1:1] == CTRL_A[ADDR_W-1:1]);
   assign any_hit  = (|win_hit) | (|port_hit) | ctrl_hit;

   // R5: no address may select two targets at once
   a_r5_single_target: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({win_hit, port_hit, ctrl_hit}));
endmodule

// File: rtl/tlr_layer.sv
module tlr_layer #(
   parameter int DATA_W  = 16,
   parameter int TILE_AW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_x,
   input  logic              wr_y,
   input  logic              wr_ptr,
   input  logic              wr_tile,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] x_q,
   output logic [DATA_W-1:0] y_q,
   output logic [DATA_W-1:0] ptr_q,
   output logic [DATA_W-1:0] tile_rd
);
   localparam int DEPTH = 1 << TILE_AW;

   logic [DATA_W-1:0]  tiles [DEPTH];
   logic [TILE_AW-1:0] idx;

   assign idx = ptr_q[TILE_AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_q   <= '0;
         y_q   <= '0;
         ptr_q <= '0;
      end else begin
         if (wr_x)   x_q   <= wdata;
         if (wr_y)   y_q   <= wdata;
         if (wr_ptr) ptr_q <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_tile) tiles[idx] <= wdata;
   end

   assign tile_rd = tiles[idx];

   // R3: pointer loads exactly the written word
   a_r3_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ptr |=> (ptr_q == $past(wdata)));
   // R3: pointer never moves without a pointer write
   a_r3_ptr_no_step: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ptr |=> $stable(ptr_q));
   // R2: scroll values hold when not written
   a_r2_x_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_x |=> $stable(x_q));
   a_r2_y_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_y |=> $stable(y_q));
   // R4: a port write is visible on the read path next cycle
   a_r4_tile_store: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_tile && !wr_ptr) |=> (tile_rd == $past(wdata)));
endmodule

// File: rtl/tlr_ctrl.sv
module tlr_ctrl #(
   parameter logic [7:0] CODE_BANK_LO = 8'd10,
   parameter logic [7:0] CODE_BANK_HI = 8'd11,
   parameter logic [7:0] CODE_IRQ_ON  = 8'd14
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [7:0] code,
   input  logic       irq_req,
   output logic       bank_q,
   output logic       irq_en_q,
   output logic       irq_out
);
   logic known;
   assign known = (code == CODE_BANK_LO) || (code == CODE_BANK_HI) || (code == CODE_IRQ_ON);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q   <= 1'b0;
         irq_en_q <= 1'b0;
      end else if (wr) begin
         case (code)
            CODE_BANK_LO: bank_q   <= 1'b0;
            CODE_BANK_HI: bank_q   <= 1'b1;
            CODE_IRQ_ON:  irq_en_q <= 1'b1;
            default: ;
         endcase
      end
   end

   assign irq_out = irq_req & irq_en_q;

   // R7: bank select follows the two bank codes
   a_r7_bank_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && code == CODE_BANK_LO) |=> !bank_q);
   a_r7_bank_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && code == CODE_BANK_HI) |=> bank_q);
   // R8: enable is set by its code and is sticky
   a_r8_irq_on: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && code == CODE_IRQ_ON) |=> irq_en_q);
   a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      irq_en_q |=> irq_en_q);
   // R8: unknown codes change nothing
   a_r8_other_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr || !known) |=> ($stable(bank_q) && $stable(irq_en_q)));
endmodule

// File: rtl/tile_layer_regs.sv
module tile_layer_regs
   import tlr_pkg::*;
#(
   parameter int          ADDR_W     = 20,
   parameter int          DATA_W     = 16,
   parameter int          NUM_LAYERS = 3,
   parameter int          TILE_AW    = 8,
   parameter int          BANK_LAYER = 2,
   parameter int unsigned WIN_BASE   = 32'h70000,
   parameter int unsigned WIN_STRIDE = 32'h2000,
   parameter int unsigned PORT_BASE  = 32'h7E000,
   parameter int unsigned CTRL_ADDR  = 32'h7800E
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         bus_sel,
   input  logic                         bus_we,
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic [DATA_W-1:0]            bus_wdata,
   output logic [DATA_W-1:0]            bus_rdata,
   output logic                         bus_ack,
   input  logic                         irq4_req,
   output logic                         irq4_out,
   output logic                         layer_bank,
   output logic [NUM_LAYERS*DATA_W-1:0] scroll_x,
   output logic [NUM_LAYERS*DATA_W-1:0] scroll_y
);
   if (NUM_LAYERS < 1 || NUM_LAYERS > 4) begin : g_bad_layers
      $error("NUM_LAYERS must be 1..4");
   end
   if (BANK_LAYER >= NUM_LAYERS) begin : g_bad_bank
      $error("BANK_LAYER must name an existing layer");
   end
   if (TILE_AW < 1 || TILE_AW > DATA_W || TILE_AW > 12) begin : g_bad_tile
      $error("TILE_AW must be 1..min(DATA_W,12)");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("DATA_W must be at least 8");
   end
   if (ADDR_W < 4 || ADDR_W > 32) begin : g_bad_addr
      $error("ADDR_W must be 4..32");
   end
   if ((WIN_BASE % 8) != 0 || (WIN_STRIDE % 8) != 0) begin : g_bad_align
      $error("layer windows must be 8-byte aligned");
   end

   logic [NUM_LAYERS-1:0] win_hit;
   logic [NUM_LAYERS-1:0] port_hit;
   tlr_field_e            win_fld;
   logic                  ctrl_hit;
   logic                  any_hit;
   logic                  wr_cyc;

   logic [DATA_W-1:0] x_q     [NUM_LAYERS];
   logic [DATA_W-1:0] y_q     [NUM_LAYERS];
   logic [DATA_W-1:0] ptr_q   [NUM_LAYERS];
   logic [DATA_W-1:0] tile_rd [NUM_LAYERS];

   logic bank_q;
   logic irq_en_q;
   logic ack_q;

   assign wr_cyc = bus_sel & bus_we;

   tlr_decode #(
      .ADDR_W(ADDR_W), .NUM_LAYERS(NUM_LAYERS), .WIN_BASE(WIN_BASE),
      .WIN_STRIDE(WIN_STRIDE), .PORT_BASE(PORT_BASE), .CTRL_ADDR(CTRL_ADDR)
   ) u_decode (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .win_hit(win_hit),
      .win_fld(win_fld), .port_hit(port_hit), .ctrl_hit(ctrl_hit), .any_hit(any_hit)
   );

   for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_layer
      logic sel_w;
      assign sel_w = wr_cyc & win_hit[l];
      tlr_layer #(.DATA_W(DATA_W), .TILE_AW(TILE_AW)) u_layer (
         .clk(clk), .rst_n(rst_n),
         .wr_x(sel_w && win_fld == FLD_X),
         .wr_y(sel_w && win_fld == FLD_Y),
         .wr_ptr(sel_w && win_fld == FLD_PTR),
         .wr_tile(wr_cyc & port_hit[l]),
         .wdata(bus_wdata),
         .x_q(x_q[l]), .y_q(y_q[l]), .ptr_q(ptr_q[l]), .tile_rd(tile_rd[l])
      );
      assign scroll_x[l*DATA_W +: DATA_W] = x_q[l];
      assign scroll_y[l*DATA_W +: DATA_W] = y_q[l];
   end

   tlr_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr(wr_cyc & ctrl_hit), .code(bus_wdata[7:0]),
      .irq_req(irq4_req), .bank_q(bank_q), .irq_en_q(irq_en_q), .irq_out(irq4_out)
   );

   assign layer_bank = bank_q;

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_we) begin
         for (int l = 0; l < NUM_LAYERS; l++) begin
            if (win_hit[l]) begin
               case (win_fld)
                  FLD_X:   bus_rdata = x_q[l];
                  FLD_Y:   bus_rdata = y_q[l];
                  FLD_PTR: bus_rdata = ptr_q[l];
                  default: ;
               endcase
            end
            if (port_hit[l]) bus_rdata = tile_rd[l];
         end
         if (ctrl_hit) begin
            bus_rdata[CTRL_BANK_BIT] = bank_q;
            bus_rdata[CTRL_IRQ_BIT]  = irq_en_q;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ack_q <= 1'b0;
      else        ack_q <= bus_sel & any_hit;
   end
   assign bus_ack = ack_q;

   // R5: decoded strobes are acknowledged next cycle, others never
   a_r5_ack_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && any_hit) |=> bus_ack);
   a_r5_no_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && any_hit) |=> !bus_ack);
   // R5: idle bus reads zero
   a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_sel |-> (bus_rdata == '0));
endmodule

// File: tb/tile_layer_regs_tb.sv
module tile_layer_regs_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [19:0] bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        bus_ack;
   logic        irq4_req = 1'b0;
   logic        irq4_out;
   logic        layer_bank;
   logic [47:0] scroll_x;
   logic [47:0] scroll_y;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   tile_layer_regs u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_ack(bus_ack), .irq4_req(irq4_req), .irq4_out(irq4_out),
      .layer_bank(layer_bank), .scroll_x(scroll_x), .scroll_y(scroll_y)
   );

   // reference model state
   logic [15:0] m_x [3];
   logic [15:0] m_y [3];
   logic [15:0] m_ptr [3];
   logic [15:0] m_tile [3][256];
   logic        m_bank, m_en, m_ack;

   // region: 0 none, 1 X, 2 Y, 3 pointer, 4 data port, 5 mode register
   function automatic int region(input logic [19:0] a, output int lay);
      int w;
      w = int'(a) & 32'hFFFFE;
      lay = 0;
      for (int l = 0; l < 3; l++) begin
         int b;
         b = 32'h70000 + l * 32'h2000;
         if (w == b)      begin lay = l; return 1; end
         if (w == b + 2)  begin lay = l; return 2; end
         if (w == b + 4)  begin lay = l; return 3; end
         if (w == 32'h7E000 + 2 * l) begin lay = l; return 4; end
      end
      if (w == 32'h7800E) return 5;
      return 0;
   endfunction

   function automatic logic [15:0] model_read(input logic [19:0] a);
      int l, r;
      r = region(a, l);
      case (r)
         1: return m_x[l];
         2: return m_y[l];
         3: return m_ptr[l];
         4: return m_tile[l][m_ptr[l] % 256];
         5: return {14'd0, m_en, m_bank};
         default: return 16'd0;
      endcase
   endfunction

   function automatic string region_tag(input logic [19:0] a);
      int l, r;
      r = region(a, l);
      case (r)
         1, 2: return "R2";
         3: return "R3";
         4: return "R4";
         5: return "R7";
         default: return "R5";
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int l = 0; l < 3; l++) begin
            m_x[l] = 0; m_y[l] = 0; m_ptr[l] = 0;
         end
         m_bank = 0; m_en = 0; m_ack = 0;
      end else begin
         int l, r;
         r = region(bus_addr, l);
         m_ack = bus_sel && (r != 0);
         if (bus_sel && bus_we) begin
            case (r)
               1: m_x[l] = bus_wdata;
               2: m_y[l] = bus_wdata;
               3: m_ptr[l] = bus_wdata;
               4: m_tile[l][m_ptr[l] % 256] = bus_wdata;
               5: begin
                  if (bus_wdata[7:0] == 8'd10) m_bank = 0;
                  else if (bus_wdata[7:0] == 8'd11) m_bank = 1;
                  else if (bus_wdata[7:0] == 8'd14) m_en = 1;
               end
               default: ;
            endcase
         end
      end
   end

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         string t_ack, t_sc, t_bk, t_irq;
         t_ack = rst_n ? "R5" : "R1";
         t_sc  = rst_n ? "R2" : "R1";
         t_bk  = rst_n ? "R7" : "R1";
         t_irq = rst_n ? "R8" : "R1";
         chk(t_ack, {15'd0, bus_ack}, {15'd0, m_ack});
         for (int l = 0; l < 3; l++) begin
            chk(t_sc, scroll_x[l*16 +: 16], m_x[l]);
            chk(t_sc, scroll_y[l*16 +: 16], m_y[l]);
         end
         chk(t_bk, {15'd0, layer_bank}, {15'd0, m_bank});
         chk(t_irq, {15'd0, irq4_out}, {15'd0, irq4_req & m_en});
      end
   end

   task automatic acc(input logic [19:0] a, input bit we, input logic [15:0] d, input string tag);
      @(posedge clk);
      #1;
      bus_sel = 1; bus_we = we; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      if (!we) chk(tag, bus_rdata, model_read(a));
      else     chk("R5", bus_rdata, 16'd0);
   endtask

   task automatic idle();
      @(posedge clk);
      #1;
      bus_sel = 0; bus_we = 0;
      @(negedge clk);
      chk("R5", bus_rdata, 16'd0);
   endtask

   function automatic logic [19:0] win(input int l, input int off);
      return 20'(32'h70000 + l * 32'h2000 + off);
   endfunction

   function automatic logic [19:0] port(input int l);
      return 20'(32'h7E000 + 2 * l);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1;
      // R1: all registers read zero after reset
      for (int l = 0; l < 3; l++) begin
         acc(win(l, 0), 0, 0, "R1");
         acc(win(l, 2), 0, 0, "R1");
         acc(win(l, 4), 0, 0, "R1");
      end
      acc(20'h7800E, 0, 0, "R1");
      idle();

      // fill tile storage through the ports (R4)
      for (int l = 0; l < 3; l++)
         for (int i = 0; i < 256; i++) begin
            acc(win(l, 4), 1, 16'(i), "R3");
            acc(port(l), 1, 16'(l * 4096 + i * 7 + 3), "R4");
         end

      // R2: scroll write and readback, with bit 0 set on the address (R5)
      acc(win(1, 0) | 20'd1, 1, 16'hBEEF, "R2");
      acc(win(1, 0), 0, 0, "R2");
      acc(win(2, 2), 1, 16'h1234, "R2");
      acc(win(2, 2) | 20'd1, 0, 0, "R2");
      idle();

      // R3: no auto-increment; two writes land in the same entry
      acc(win(0, 4), 1, 16'd3, "R3");
      acc(port(0), 1, 16'hAAAA, "R4");
      acc(port(0), 1, 16'h5555, "R4");
      acc(port(0), 0, 0, "R3");
      acc(win(0, 4), 0, 0, "R3");
      acc(win(0, 4), 1, 16'd4, "R3");
      acc(port(0), 0, 0, "R3");

      // R9: high pointer bits alias onto the low entry
      acc(win(2, 4), 1, 16'h0105, "R9");
      acc(port(2), 1, 16'hC0DE, "R9");
      acc(win(2, 4), 1, 16'h0005, "R9");
      acc(port(2), 0, 0, "R9");

      // R6: other layers' entries untouched
      acc(win(1, 4), 1, 16'h0005, "R6");
      acc(port(1), 0, 0, "R6");
      acc(win(0, 4), 1, 16'h0005, "R6");
      acc(port(0), 0, 0, "R6");

      // R5: undecoded addresses
      acc(20'h7800C, 1, 16'd11, "R5");
      acc(20'h7800C, 0, 0, "R5");
      acc(win(0, 6), 0, 0, "R5");
      acc(20'h7E006, 0, 0, "R5");
      acc(20'h40000, 0, 0, "R5");
      idle();

      // R7, R8: mode register
      acc(20'h7800E, 1, 16'h550B, "R7");
      acc(20'h7800E, 0, 0, "R7");
      acc(20'h7800E, 1, 16'd10, "R7");
      acc(20'h7800E, 0, 0, "R7");
      irq4_req = 1;
      acc(20'h7800E, 1, 16'd15, "R8");
      acc(20'h7800E, 1, 16'd12, "R8");
      acc(20'h7800E, 0, 0, "R8");
      acc(20'h7800E, 1, 16'd14, "R8");
      acc(20'h7800E, 0, 0, "R8");
      acc(20'h7800E, 1, 16'd11, "R7");
      acc(20'h7800E, 1, 16'h0099, "R8");
      acc(20'h7800E, 0, 0, "R8");
      irq4_req = 0;
      idle();

      // mixed traffic
      for (int n = 0; n < 4000; n++) begin
         logic [19:0] a;
         logic [15:0] d;
         int k, l;
         bit we;
         k = $urandom_range(0, 19);
         l = $urandom_range(0, 2);
         case (k)
            0, 1, 2:    a = win(l, 0);
            3, 4:       a = win(l, 2);
            5, 6, 7:    a = win(l, 4);
            8, 9, 10, 11, 12: a = port(l);
            13, 14:     a = 20'h7800E;
            15:         a = 20'h7800C;
            16:         a = win(l, 6);
            17:         a = 20'h7E006;
            default:    a = 20'($urandom_range(0, 32'hFFFFF));
         endcase
         a[0] = 1'($urandom_range(0, 1));
         d = 16'($urandom);
         if (k == 13 || k == 14) begin
            case ($urandom_range(0, 3))
               0: d[7:0] = 8'd10;
               1: d[7:0] = 8'd11;
               2: d[7:0] = 8'd14;
               default: ;
            endcase
         end
         we = 1'($urandom_range(0, 1));
         irq4_req = 1'($urandom_range(0, 1));
         if ($urandom_range(0, 7) == 0) idle();
         else acc(a, we, d, region_tag(a));
      end
      idle();
      idle();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule